// File: doc/BRIEF.md
# Parallel Peripheral Host Port

This block lets an external microprocessor use a processor core as a byte-wide peripheral. The host writes bytes into an inbound data register, and the core collects them. The core writes bytes into an outbound data register, and the host collects them. The host drives asynchronous active-low write and read strobes. Each strobe passes through a multi-stage synchroniser into the core clock domain, where an edge detector turns it into a one-cycle event. The core side uses plain single-cycle read and write pulses.

Two mode inputs choose passive or active strobe handling, one for the inbound direction and one for the outbound direction. Each handshake flag is shown only while its own direction is passive, and is held at 0 otherwise. The port is in peripheral mode only when both directions are passive. In that mode the select-0 output stops passing the channel-select input and instead carries the OR of the two flags. A low level on select-0 therefore tells the host that either kind of access may proceed. The core can also poll both flags through a status word.

Top module: `host_pport`

## Requirements
- R1: After reset, `coreInData` and `hostDataOut` are 0 and `inFull` is 0. `outEmpty` is 1 while `outPassive` is 1.
- R2: A host write loads `hostDataIn` into the inbound register and sets the inbound full state.
- R3: A core read pulse (`coreRdIn` high for one cycle) clears `inFull` at the next clock edge, unless a host write event occurs in the same cycle.
- R4: A core write pulse loads `coreWrData` into the outbound register (`hostDataOut`) and clears `outEmpty` at the next clock edge.
- R5: When the host read strobe `hostRdN` is released (rises), `outEmpty` is set to 1 again.
- R6: `inFull` is 0 whenever `inPassive` is 0, and `outEmpty` is 0 whenever `outPassive` is 0. The underlying state is kept and shows again once the mode returns to passive.
- R7: When `inPassive` and `outPassive` are both 1, `sel0` equals `inFull | outEmpty`. Otherwise `sel0` follows `chanSelIn`.
- R8: `coreStatus` bit 0 equals `inFull`, bit 1 equals `outEmpty`, and all other bits are 0.
- R9: If a host write event and a core read pulse fall in the same cycle, the write wins. `inFull` stays 1 and the new byte is held.
- R10: With SYNC_STAGES=2, a falling `hostWrN` takes effect at the third rising clock edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inPassive | input | 1 | Inbound strobe mode, 1 = passive |
| outPassive | input | 1 | Outbound strobe mode, 1 = passive |
| chanSelIn | input | 1 | Channel select passed to `sel0` outside peripheral mode |
| hostWrN | input | 1 | Host write strobe, active low, asynchronous |
| hostRdN | input | 1 | Host read strobe, active low, asynchronous |
| hostDataIn | input | DATA_W | Host write data |
| hostDataOut | output | DATA_W | Outbound register contents for the host |
| coreRdIn | input | 1 | Core read pulse for the inbound register |
| coreInData | output | DATA_W | Inbound register contents for the core |
| coreWr | input | 1 | Core write pulse for the outbound register |
| coreWrData | input | DATA_W | Core write data |
| coreStatus | output | STAT_W | Pollable status word |
| inFull | output | 1 | Inbound buffer full flag, active high |
| outEmpty | output | 1 | Outbound buffer empty flag, active high |
| sel0 | output | 1 | Channel select, or the ready indication in peripheral mode |

## Verification
The bench uses the default parameters: DATA_W=8, SYNC_STAGES=2 and STAT_W=8. With two synchroniser stages the host-strobe latency is a fixed three edges. This lets the bench check the not-yet and now cycles exactly, and place a core read in the same cycle as a host write event. The 8-bit width puts the all-zero and all-one bytes within reach, and the 8-bit status word exposes the unused bits so the bench can check that they read as 0.

// File: rtl/host_pport_pkg.sv
package host_pport_pkg;
  localparam int FULL_BIT  = 0;
  localparam int EMPTY_BIT = 1;

  typedef struct packed {
    logic loadIn;
    logic loadOut;
  } pportStrobe_t;
endpackage

// File: rtl/host_pport_sync.sv
module host_pport_sync #(
  parameter int STAGES = 2,
  parameter int NUM    = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NUM-1:0] strobeN,
  output logic [NUM-1:0] assertEv,
  output logic [NUM-1:0] releaseEv
);
  generate
    for (genvar g = 0; g < NUM; g++) begin : g_line
      // chain[STAGES-1] is the synchronised level; chain[STAGES] is its previous value
      logic [STAGES:0] chain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[STAGES-1:0], strobeN[g]};
      end
      assign assertEv[g]  = chain[STAGES] & ~chain[STAGES-1];
      assign releaseEv[g] = ~chain[STAGES] & chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/host_pport_ctrl.sv
module host_pport_ctrl
  import host_pport_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEv,
  input  logic              hostRdEv,
  input  logic              coreRdIn,
  input  logic              coreWr,
  input  logic              inPassive,
  input  logic              outPassive,
  input  logic              chanSelIn,
  output pportStrobe_t      strobe,
  output logic              inFull,
  output logic              outEmpty,
  output logic              sel0,
  output logic [STAT_W-1:0] coreStatus
);
  logic fullRaw;
  logic emptyRaw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         fullRaw <= 1'b0;
    else if (hostWrEv) fullRaw <= 1'b1;
    else if (coreRdIn) fullRaw <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         emptyRaw <= 1'b1;
    else if (coreWr)   emptyRaw <= 1'b0;
    else if (hostRdEv) emptyRaw <= 1'b1;
  end

  always_comb begin
    strobe.loadIn  = hostWrEv;
    strobe.loadOut = coreWr;
    inFull   = fullRaw & inPassive;
    outEmpty = emptyRaw & outPassive;
    sel0     = (inPassive && outPassive) ? (inFull | outEmpty) : chanSelIn;
    coreStatus            = '0;
    coreStatus[FULL_BIT]  = inFull;
    coreStatus[EMPTY_BIT] = outEmpty;
  end
endmodule

// File: rtl/host_pport_dp.sv
module host_pport_dp
  import host_pport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pportStrobe_t      strobe,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic [DATA_W-1:0] coreWrData,
  output logic [DATA_W-1:0] coreInData,
  output logic [DATA_W-1:0] hostDataOut
);
  logic [DATA_W-1:0] inReg;
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              inReg <= '0;
    else if (strobe.loadIn) inReg <= hostDataIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outReg <= '0;
    else if (strobe.loadOut) outReg <= coreWrData;
  end

  assign coreInData  = inReg;
  assign hostDataOut = outReg;
endmodule

// File: rtl/host_pport.sv
module host_pport
  import host_pport_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int STAT_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inPassive,
  input  logic              outPassive,
  input  logic              chanSelIn,
  input  logic              hostWrN,
  input  logic              hostRdN,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  input  logic              coreRdIn,
  output logic [DATA_W-1:0] coreInData,
  input  logic              coreWr,
  input  logic [DATA_W-1:0] coreWrData,
  output logic [STAT_W-1:0] coreStatus,
  output logic              inFull,
  output logic              outEmpty,
  output logic              sel0
);
  localparam int NUM_STROBES = 2;

  logic [NUM_STROBES-1:0] assertEv;
  logic [NUM_STROBES-1:0] releaseEv;
  logic                   hostWrEv;
  logic                   hostRdEv;
  pportStrobe_t           strobe;

  host_pport_sync #(.STAGES(SYNC_STAGES), .NUM(NUM_STROBES)) u_sync (
    .clk       (clk),
    .rstN      (rstN),
    .strobeN   ({hostRdN, hostWrN}),
    .assertEv  (assertEv),
    .releaseEv (releaseEv)
  );

  assign hostWrEv = assertEv[0];
  assign hostRdEv = releaseEv[1];

  host_pport_ctrl #(.STAT_W(STAT_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostWrEv   (hostWrEv),
    .hostRdEv   (hostRdEv),
    .coreRdIn   (coreRdIn),
    .coreWr     (coreWr),
    .inPassive  (inPassive),
    .outPassive (outPassive),
    .chanSelIn  (chanSelIn),
    .strobe     (strobe),
    .inFull     (inFull),
    .outEmpty   (outEmpty),
    .sel0       (sel0),
    .coreStatus (coreStatus)
  );

  host_pport_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .hostDataIn  (hostDataIn),
    .coreWrData  (coreWrData),
    .coreInData  (coreInData),
    .hostDataOut (hostDataOut)
  );
endmodule

// File: rtl/host_pport_chk.sv
module host_pport_chk #(
  parameter int DATA_W = 8,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              inPassive,
  input logic              outPassive,
  input logic              chanSelIn,
  input logic              coreRdIn,
  input logic              coreWr,
  input logic [DATA_W-1:0] coreWrData,
  input logic [DATA_W-1:0] hostDataOut,
  input logic [STAT_W-1:0] coreStatus,
  input logic              inFull,
  input logic              outEmpty,
  input logic              sel0,
  input logic              hostWrEv,
  input logic              hostRdEv
);
  p_wr_sets_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEv |=> (inFull || !inPassive));

  p_rd_clears_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    (coreRdIn && !hostWrEv) |=> !inFull);

  p_core_wr_r4: assert property (@(posedge clk) disable iff (!rstN)
    coreWr |=> (!outEmpty && hostDataOut == $past(coreWrData)));

  p_rd_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEv && !coreWr) |=> (outEmpty || !outPassive));

  p_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!inPassive |-> !inFull) and (!outPassive |-> !outEmpty));

  p_ready_sel_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inPassive && outPassive) |-> (sel0 == (inFull | outEmpty)));

  p_chan_sel_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(inPassive && outPassive) |-> (sel0 == chanSelIn));

  p_status_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(coreStatus) == $countones({inFull, outEmpty})) &&
    coreStatus[0] == inFull && coreStatus[1] == outEmpty);

  p_collide_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEv && coreRdIn && inPassive && $stable(inPassive)) |=> (inFull || !inPassive));
endmodule

bind host_pport host_pport_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .inPassive   (inPassive),
  .outPassive  (outPassive),
  .chanSelIn   (chanSelIn),
  .coreRdIn    (coreRdIn),
  .coreWr      (coreWr),
  .coreWrData  (coreWrData),
  .hostDataOut (hostDataOut),
  .coreStatus  (coreStatus),
  .inFull      (inFull),
  .outEmpty    (outEmpty),
  .sel0        (sel0),
  .hostWrEv    (hostWrEv),
  .hostRdEv    (hostRdEv)
);

// File: tb/test_host_pport.sv
module test_host_pport;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int SW = 8;

  // op: 0 host write, 1 core read, 2 core write, 3 host read
  typedef struct packed {
    logic [1:0]    op;
    logic [DW-1:0] data;
    logic          full;
    logic          empty;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 8'hA5, 1'b1, 1'b1},
    '{2'd1, 8'hA5, 1'b0, 1'b1},
    '{2'd2, 8'h3C, 1'b0, 1'b0},
    '{2'd3, 8'h3C, 1'b0, 1'b1},
    '{2'd0, 8'hFF, 1'b1, 1'b1},
    '{2'd2, 8'h00, 1'b1, 1'b0},
    '{2'd3, 8'h00, 1'b1, 1'b1},
    '{2'd1, 8'hFF, 1'b0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inPassive = 1'b1, outPassive = 1'b1, chanSelIn = 1'b0;
  logic          hostWrN = 1'b1, hostRdN = 1'b1;
  logic [DW-1:0] hostDataIn = '0, hostDataOut, coreInData, coreWrData = '0;
  logic          coreRdIn = 1'b0, coreWr = 1'b0;
  logic [SW-1:0] coreStatus;
  logic          inFull, outEmpty, sel0;
  logic [DW-1:0] readVal;
  int            tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_pport i_host_pport (
    .clk(clk), .rstN(rstN), .inPassive(inPassive), .outPassive(outPassive),
    .chanSelIn(chanSelIn), .hostWrN(hostWrN), .hostRdN(hostRdN),
    .hostDataIn(hostDataIn), .hostDataOut(hostDataOut), .coreRdIn(coreRdIn),
    .coreInData(coreInData), .coreWr(coreWr), .coreWrData(coreWrData),
    .coreStatus(coreStatus), .inFull(inFull), .outEmpty(outEmpty), .sel0(sel0)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [DW-1:0] d);
    @(negedge clk); hostDataIn = d; hostWrN = 1'b0;
    repeat (4) @(negedge clk);
    hostWrN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic hostRead(output logic [DW-1:0] d);
    @(negedge clk); hostRdN = 1'b0;
    repeat (4) @(negedge clk);
    d = hostDataOut; hostRdN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic coreRead(output logic [DW-1:0] d);
    @(negedge clk); coreRdIn = 1'b1; d = coreInData;
    @(negedge clk); coreRdIn = 1'b0;
  endtask

  task automatic coreWrite(input logic [DW-1:0] d);
    @(negedge clk); coreWr = 1'b1; coreWrData = d;
    @(negedge clk); coreWr = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 inFull", inFull, 0);
    chk("R1 outEmpty", outEmpty, 1);
    chk("R1 coreInData", coreInData, 0);
    chk("R1 hostDataOut", hostDataOut, 0);

    // table walk in peripheral mode: R2 R3 R4 R5 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      case (VECS[i].op)
        2'd0: begin hostWrite(VECS[i].data); chk("R2 data", coreInData, VECS[i].data); end
        2'd1: begin coreRead(readVal); chk("R3 data", readVal, VECS[i].data); end
        2'd2: begin coreWrite(VECS[i].data); chk("R4 data", hostDataOut, VECS[i].data); end
        default: begin hostRead(readVal); chk("R5 data", readVal, VECS[i].data); end
      endcase
      chk("R2_R3 inFull", inFull, VECS[i].full);
      chk("R4_R5 outEmpty", outEmpty, VECS[i].empty);
      chk("R7 sel0", sel0, VECS[i].full | VECS[i].empty);
      chk("R8 status", coreStatus, {6'b0, VECS[i].empty, VECS[i].full});
    end

    // R6 inbound gating with state kept
    inPassive = 1'b0; chanSelIn = 1'b1;
    hostWrite(8'h5A);
    chk("R6 inFull gated", inFull, 0);
    chk("R8 status gated", coreStatus, 8'h02);
    chk("R7 sel0 follows chanSelIn", sel0, 1);
    chanSelIn = 1'b0; #1;
    chk("R7 sel0 follows chanSelIn low", sel0, 0);
    inPassive = 1'b1; #1;
    chk("R6 inFull restored", inFull, 1);
    // R6 outbound gating
    outPassive = 1'b0; #1;
    chk("R6 outEmpty gated", outEmpty, 0);
    chk("R7 sel0 non-peripheral", sel0, 0);
    outPassive = 1'b1; #1;
    chk("R6 outEmpty restored", outEmpty, 1);
    coreRead(readVal);
    chk("R3 cleared", inFull, 0);

    // R10 latency
    @(negedge clk); hostDataIn = 8'h11; hostWrN = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 not before third edge", inFull, 0);
    @(negedge clk);
    chk("R10 at third edge", inFull, 1);
    hostWrN = 1'b1;
    repeat (4) @(negedge clk);

    // R9 collision: host write event and core read same cycle
    @(negedge clk); hostDataIn = 8'h77; hostWrN = 1'b0;
    @(negedge clk); @(negedge clk); coreRdIn = 1'b1;
    @(negedge clk); coreRdIn = 1'b0;
    chk("R9 full kept", inFull, 1);
    chk("R9 new data", coreInData, 8'h77);
    hostWrN = 1'b1;
    repeat (4) @(negedge clk);

    // R4 clear on core write takes one edge
    @(negedge clk); coreWr = 1'b1; coreWrData = 8'hC3;
    @(negedge clk); coreWr = 1'b0;
    chk("R4 empty cleared", outEmpty, 0);
    chk("R7 sel0 with full", sel0, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule